// File: doc/BRIEF.md
# Dual Guarded Accumulator with Saturation

This block holds two 40-bit signed accumulators, called A and B, for a multiply-accumulate datapath. Each operation forms the signed product of two 16-bit operands and then, for the accumulator chosen by `acc_sel`, clears it, loads the product, adds the product or subtracts the product. The result is registered on the clock edge that follows the request. The 32-bit product range is widened by 8 guard bits, so a run of accumulations can grow past 32 bits without losing its sign.

Each accumulator has two status flags. The overflow flag shows whether the latest result on that accumulator left the signed 32-bit range. The sticky saturation flag records a clamp, or a 40-bit wrap when clamping is off. It stays set until `sat_clr` is asserted. Two summary outputs OR the per-accumulator flags together.

Top module: `dual_acc_sat`

## Requirements
- R1: After a synchronous active-low reset, both accumulators read 0 and all six flag outputs read 0.
- R2: With `op_en`=1 and `op_code`=2'b01 (multiply-accumulate), the selected accumulator (`acc_sel`=0 selects A, 1 selects B) becomes its old value plus the signed product of `opnd_x` and `opnd_y`. The new value appears after the next rising edge. The other accumulator and its flags do not change.
- R3: With `op_code`=2'b10 (multiply-subtract), the selected accumulator becomes its old value minus the signed product.
- R4: `op_code`=2'b11 (load) writes the product, sign-extended to 40 bits. `op_code`=2'b00 (clear) writes 0. Both leave that accumulator's overflow flag at 0.
- R5: While `op_en`=0, neither accumulator nor any overflow flag changes, whatever the other inputs are.
- R6: Every enabled operation on an accumulator sets its overflow flag to 1 when the exact result lies outside -2^31 .. 2^31-1, and to 0 otherwise.
- R7: With `sat_en`=1, an exact result above 2^31-1 is stored as 0x007FFFFFFF and one below -2^31 as 0xFF80000000. Either case sets that accumulator's saturation flag.
- R8: With `sat_en`=0, the result wraps modulo 2^40. The saturation flag is set only when the exact result leaves the signed 40-bit range.
- R9: A saturation flag, once set, stays set until `sat_clr`=1 clears both flags on the next edge. If a new saturation event occurs in the same cycle as the clear, the flag ends set.
- R10: `ovf_any` equals `ovf_a` OR `ovf_b`, and `sat_any` equals `sat_a` OR `sat_b`.
- R11: Operands are two's-complement. (-32768) x (-32768) yields +2^30, and (-32768) x 32767 yields -1073709056.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_en | input | 1 | Perform `op_code` on the selected accumulator this cycle |
| acc_sel | input | 1 | 0 = accumulator A, 1 = accumulator B |
| op_code | input | 2 | 00 clear, 01 multiply-accumulate, 10 multiply-subtract, 11 load |
| sat_en | input | 1 | 1 = clamp to the 32-bit range, 0 = wrap at 40 bits |
| sat_clr | input | 1 | Clear both sticky saturation flags |
| opnd_x | input | 16 | Signed multiplicand |
| opnd_y | input | 16 | Signed multiplier |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | A's latest result left the 32-bit range |
| ovf_b | output | 1 | B's latest result left the 32-bit range |
| sat_a | output | 1 | Sticky saturation/wrap flag of A |
| sat_b | output | 1 | Sticky saturation/wrap flag of B |
| ovf_any | output | 1 | OR of the overflow flags |
| sat_any | output | 1 | OR of the saturation flags |

## Verification
Small mixed-sign products show that add and subtract work and that only the selected bank is written. The most-negative operand pair shows that the inputs are treated as two's-complement. Repeated large positive products on A, and large negative products on B, push the results past the 32-bit bounds in both directions. This is done once with clamping and once without, which separates the clamp values from guard-bit growth and shows that the overflow flag drops again when the result comes back into range. A run of about 520 accumulations of 2^30 crosses the 40-bit limit, which shows the wrap and the sticky flag it sets. Flag-clear cycles with and without a new event show which of the two wins.

// File: rtl/dacc_pkg.sv
// Package: shared operation encoding for the dual accumulator.
// Assumes: the two-bit op field is decoded identically by every bank.
package dacc_pkg;
    typedef enum logic [1:0] {
        ACC_CLR = 2'b00,
        ACC_MAC = 2'b01,
        ACC_MSC = 2'b10,
        ACC_LD  = 2'b11
    } acc_op_e;
endpackage

// File: rtl/dacc_mult.sv
// Module: dacc_mult
// Forms the signed product of two OP_W-bit two's-complement operands.
// Assumes: the product of two OP_W-bit signed values always fits in
// 2*OP_W signed bits, so the low 2*OP_W bits of a product of
// sign-extended operands are exact.
module dacc_mult #(
    parameter int OP_W = 16
) (
    input  logic [OP_W-1:0]   mul_x,
    input  logic [OP_W-1:0]   mul_y,
    output logic [2*OP_W-1:0] mul_p
);
    localparam int PW = 2 * OP_W;

    logic signed [PW-1:0] x_ext;
    logic signed [PW-1:0] y_ext;

    // Sign-extend both operands to the product width.
    always_comb begin
        x_ext = $signed({{OP_W{mul_x[OP_W-1]}}, mul_x});
        y_ext = $signed({{OP_W{mul_y[OP_W-1]}}, mul_y});
    end

    // Signed multiply, truncated to the exact product width.
    always_comb begin
        mul_p = x_ext * y_ext;
    end
endmodule

// File: rtl/dacc_addsat.sv
// Module: dacc_addsat
// Computes the next value of one accumulator from its current value, the
// product and the operation, and optionally clamps it to the working range.
// Assumes: ACC_W = PROD_W + guard bits; the working range is PROD_W signed
// bits; an extra top bit carries the exact sign of the sum.
module dacc_addsat
    import dacc_pkg::*;
#(
    parameter int PROD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic [ACC_W-1:0]  cur_acc,
    input  logic [PROD_W-1:0] prod,
    input  acc_op_e           op,
    input  logic              sat_en,
    output logic [ACC_W-1:0]  nxt_acc,
    output logic              nxt_ovf,
    output logic              sat_evt
);
    localparam int GUARD_W = ACC_W - PROD_W;
    localparam int XW      = ACC_W + 1;
    localparam logic [ACC_W-1:0] POS_LIM = {{(GUARD_W+1){1'b0}}, {(PROD_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIM = {{(GUARD_W+1){1'b1}}, {(PROD_W-1){1'b0}}};

    logic [XW-1:0]     acc_x;
    logic [XW-1:0]     prod_x;
    logic [XW-1:0]     exact;
    logic [GUARD_W:0]  top_bits;
    logic              wide_ovf;
    logic              out_range;

    // Widen both terms by sign extension so the sum is exact.
    always_comb begin
        acc_x  = {acc_x_sign(cur_acc), cur_acc};
        prod_x = {{(XW-PROD_W){prod[PROD_W-1]}}, prod};
    end

    function automatic logic acc_x_sign(input logic [ACC_W-1:0] v);
        return v[ACC_W-1];
    endfunction

    // Select the exact result for the requested operation.
    always_comb begin
        unique case (op)
            ACC_CLR: exact = '0;
            ACC_LD:  exact = prod_x;
            ACC_MAC: exact = acc_x + prod_x;
            ACC_MSC: exact = acc_x - prod_x;
            default: exact = '0;
        endcase
    end

    // Detect leaving the 40-bit range and leaving the 32-bit range.
    always_comb begin
        wide_ovf  = exact[XW-1] ^ exact[ACC_W-1];
        top_bits  = exact[ACC_W-1:PROD_W-1];
        out_range = wide_ovf | ~((&top_bits) | ~(|top_bits));
    end

    // Clamp or wrap, and report a saturation event.
    always_comb begin
        nxt_ovf = out_range;
        if (sat_en && out_range) begin
            nxt_acc = exact[XW-1] ? NEG_LIM : POS_LIM;
            sat_evt = 1'b1;
        end else begin
            nxt_acc = exact[ACC_W-1:0];
            sat_evt = ~sat_en & wide_ovf;
        end
    end
endmodule

// File: rtl/dacc_bank.sv
// Module: dacc_bank
// Holds one accumulator, its overflow flag and its sticky saturation flag.
// Assumes: upd is high only when this bank is the enabled target; the next
// values come from dacc_addsat; flag clear and new event may coincide and
// the event then wins.
module dacc_bank
    import dacc_pkg::*;
#(
    parameter int PROD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             sat_clr,
    input  acc_op_e          op,
    input  logic             sat_en,
    input  logic [ACC_W-1:0] nxt_acc,
    input  logic             nxt_ovf,
    input  logic             sat_evt,
    output logic [ACC_W-1:0] acc_q,
    output logic             ovf_q,
    output logic             sat_q
);
    localparam int GUARD_W = ACC_W - PROD_W;

    // Accumulator and overflow register: written only on an update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else if (upd) begin
            acc_q <= nxt_acc;
            ovf_q <= nxt_ovf;
        end
    end

    // Sticky saturation flag: clear request first, new event overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sat_q <= 1'b0;
        end else begin
            sat_q <= (sat_q & ~sat_clr) | (upd & sat_evt);
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(acc_q) && $stable(ovf_q)); // R5

    AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && sat_en) |=> ((&acc_q[ACC_W-1:PROD_W-1]) || !(|acc_q[ACC_W-1:PROD_W-1]))); // R7

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && op == ACC_CLR) |=> (acc_q == '0) && !ovf_q); // R4

    AST_STICKY_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_q && !sat_clr) |=> sat_q); // R9

    AST_SAT_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_q && !upd) |=> !sat_q); // R9

    initial begin
        assert (GUARD_W > 0) else $error("guard width must be positive");
    end
endmodule

// File: rtl/dual_acc_sat.sv
// Module: dual_acc_sat (top)
// Two 40-bit guarded accumulators sharing one signed multiplier. Each
// enabled cycle clears, loads, adds to or subtracts from the selected
// accumulator; flags and values update on the following edge.
// Assumes: synchronous active-low reset; inputs are stable around the edge.
module dual_acc_sat
    import dacc_pkg::*;
#(
    parameter int OP_W    = 16,
    parameter int GUARD_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      op_en,
    input  logic                      acc_sel,
    input  logic [1:0]                op_code,
    input  logic                      sat_en,
    input  logic                      sat_clr,
    input  logic [OP_W-1:0]           opnd_x,
    input  logic [OP_W-1:0]           opnd_y,
    output logic [2*OP_W+GUARD_W-1:0] acc_a,
    output logic [2*OP_W+GUARD_W-1:0] acc_b,
    output logic                      ovf_a,
    output logic                      ovf_b,
    output logic                      sat_a,
    output logic                      sat_b,
    output logic                      ovf_any,
    output logic                      sat_any
);
    localparam int PROD_W = 2 * OP_W;
    localparam int ACC_W  = PROD_W + GUARD_W;
    localparam int NBANK  = 2;

    logic [PROD_W-1:0] prod;
    acc_op_e           op;
    logic [ACC_W-1:0]  acc_q   [NBANK];
    logic [NBANK-1:0]  ovf_q;
    logic [NBANK-1:0]  sat_q;

    // Decode the raw op field into the shared enum.
    always_comb begin
        op = acc_op_e'(op_code);
    end

    dacc_mult #(.OP_W(OP_W)) u_mult (
        .mul_x (opnd_x),
        .mul_y (opnd_y),
        .mul_p (prod)
    );

    for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
        logic [ACC_W-1:0] nxt_acc;
        logic             nxt_ovf;
        logic             sat_evt;
        logic             upd;

        // This bank is written when enabled and selected.
        always_comb begin
            upd = op_en && (acc_sel == (gi == 1));
        end

        dacc_addsat #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_addsat (
            .cur_acc (acc_q[gi]),
            .prod    (prod),
            .op      (op),
            .sat_en  (sat_en),
            .nxt_acc (nxt_acc),
            .nxt_ovf (nxt_ovf),
            .sat_evt (sat_evt)
        );

        dacc_bank #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd     (upd),
            .sat_clr (sat_clr),
            .op      (op),
            .sat_en  (sat_en),
            .nxt_acc (nxt_acc),
            .nxt_ovf (nxt_ovf),
            .sat_evt (sat_evt),
            .acc_q   (acc_q[gi]),
            .ovf_q   (ovf_q[gi]),
            .sat_q   (sat_q[gi])
        );
    end

    // Drive the named outputs and the OR summaries.
    always_comb begin
        acc_a   = acc_q[0];
        acc_b   = acc_q[1];
        ovf_a   = ovf_q[0];
        ovf_b   = ovf_q[1];
        sat_a   = sat_q[0];
        sat_b   = sat_q[1];
        ovf_any = |ovf_q;
        sat_any = |sat_q;
    end

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(acc_a) || $stable(acc_b))); // R2

    AST_UNSEL_B: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && !acc_sel) |=> $stable(acc_b) && $stable(ovf_b)); // R2
endmodule

// File: tb/tb_dual_acc_sat.sv
module tb_dual_acc_sat;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_en, acc_sel, sat_en, sat_clr;
    logic [1:0]  op_code;
    logic [15:0] opnd_x, opnd_y;
    logic [39:0] acc_a, acc_b;
    logic        ovf_a, ovf_b, sat_a, sat_b, ovf_any, sat_any;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [39:0] m_acc [2];
    logic        m_ovf [2];
    logic        m_sat [2];

    always #2 clk = ~clk;

    dual_acc_sat dut (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .acc_sel(acc_sel),
        .op_code(op_code), .sat_en(sat_en), .sat_clr(sat_clr),
        .opnd_x(opnd_x), .opnd_y(opnd_y), .acc_a(acc_a), .acc_b(acc_b),
        .ovf_a(ovf_a), .ovf_b(ovf_b), .sat_a(sat_a), .sat_b(sat_b),
        .ovf_any(ovf_any), .sat_any(sat_any)
    );

    task automatic chk(input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "acc_a", acc_a, m_acc[0]);
        chk(req, "acc_b", acc_b, m_acc[1]);
        chk(req, "ovf_a", 40'(ovf_a), 40'(m_ovf[0]));
        chk(req, "ovf_b", 40'(ovf_b), 40'(m_ovf[1]));
        chk(req, "sat_a", 40'(sat_a), 40'(m_sat[0]));
        chk(req, "sat_b", 40'(sat_b), 40'(m_sat[1]));
        chk("R10", "ovf_any", 40'(ovf_any), 40'(m_ovf[0] | m_ovf[1]));
        chk("R10", "sat_any", 40'(sat_any), 40'(m_sat[0] | m_sat[1]));
    endtask

    // One cycle of stimulus plus the reference update from the requirements.
    task automatic do_op(input bit en, input bit sel, input logic [1:0] opc,
                         input logic [15:0] x, input logic [15:0] y,
                         input bit sat, input bit clr, input string req);
        longint p, cur, t;
        logic [63:0] tw;
        bit rng, wide, evt;
        @(negedge clk);
        op_en = en; acc_sel = sel; op_code = opc; opnd_x = x; opnd_y = y;
        sat_en = sat; sat_clr = clr;
        p   = longint'($signed(x)) * longint'($signed(y));
        cur = longint'($signed(m_acc[sel]));
        case (opc)
            2'b00: t = 0;
            2'b11: t = p;
            2'b01: t = cur + p;
            default: t = cur - p;
        endcase
        rng  = (t > 64'sd2147483647) || (t < -64'sd2147483648);
        wide = (t > 64'sd549755813887) || (t < -64'sd549755813888);
        evt  = 1'b0;
        for (int k = 0; k < 2; k++) if (clr) m_sat[k] = 1'b0;
        if (en) begin
            m_ovf[sel] = rng;
            if (sat && rng) begin
                tw = (t > 0) ? 64'h7FFFFFFF : 64'hFFFFFFFF80000000;
                evt = 1'b1;
            end else begin
                tw = t;
                evt = !sat && wide;
            end
            m_acc[sel] = tw[39:0];
            if (evt) m_sat[sel] = 1'b1;
        end
        @(negedge clk);
        op_en = 1'b0; sat_clr = 1'b0;
        chk_all(req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; op_en = 1'b0; acc_sel = 1'b0; op_code = 2'b00;
        sat_en = 1'b0; sat_clr = 1'b0; opnd_x = '0; opnd_y = '0;
        for (int k = 0; k < 2; k++) begin m_acc[k] = '0; m_ovf[k] = 1'b0; m_sat[k] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1");
    endtask

    task automatic t_basic();
        do_op(1, 0, 2'b01, 16'd300, 16'hFFF6, 0, 0, "R2");  // 300 * -10
        do_op(1, 0, 2'b01, 16'd7, 16'd9, 0, 0, "R2");
        do_op(1, 1, 2'b10, 16'd1234, 16'd5, 0, 0, "R3");
        do_op(1, 1, 2'b10, 16'hFF00, 16'd3, 0, 0, "R3");
        do_op(1, 0, 2'b11, 16'h8000, 16'h8000, 0, 0, "R11");
        chk("R11", "acc_a +2^30", acc_a, 40'h0040000000);
        do_op(1, 1, 2'b11, 16'h8000, 16'h7FFF, 0, 0, "R11");
        chk("R11", "acc_b -1073709056", acc_b, 40'hFFC0008000);
        do_op(1, 0, 2'b00, 16'h1234, 16'h5678, 0, 0, "R4");
        do_op(0, 1, 2'b01, 16'h7FFF, 16'h7FFF, 1, 0, "R5");
        do_op(0, 0, 2'b11, 16'h1111, 16'h2222, 0, 0, "R5");
    endtask

    task automatic t_ovf_wrap();
        do_op(1, 0, 2'b11, 16'h7FFF, 16'h7FFF, 0, 0, "R4");
        for (int i = 0; i < 3; i++) do_op(1, 0, 2'b01, 16'h7FFF, 16'h7FFF, 0, 0, "R6");
        chk("R8", "no sat when guard absorbs", 40'(sat_a), 40'd0);
        chk("R6", "ovf_a above range", 40'(ovf_a), 40'd1);
        for (int i = 0; i < 3; i++) do_op(1, 0, 2'b10, 16'h7FFF, 16'h7FFF, 0, 0, "R6");
        chk("R6", "ovf_a back in range", 40'(ovf_a), 40'd0);
    endtask

    task automatic t_clamp();
        do_op(1, 0, 2'b11, 16'h7FFF, 16'h7FFF, 1, 0, "R4");
        do_op(1, 0, 2'b01, 16'h7FFF, 16'h7FFF, 1, 0, "R7");
        do_op(1, 0, 2'b01, 16'h7FFF, 16'h7FFF, 1, 0, "R7");
        chk("R7", "positive clamp", acc_a, 40'h007FFFFFFF);
        do_op(1, 1, 2'b11, 16'h8000, 16'h7FFF, 1, 0, "R4");
        do_op(1, 1, 2'b01, 16'h8000, 16'h7FFF, 1, 0, "R7");
        do_op(1, 1, 2'b01, 16'h8000, 16'h7FFF, 1, 0, "R7");
        chk("R7", "negative clamp", acc_b, 40'hFF80000000);
        chk("R7", "sat_b set", 40'(sat_b), 40'd1);
    endtask

    task automatic t_sticky();
        do_op(1, 0, 2'b00, 16'd0, 16'd0, 0, 0, "R9");
        chk("R9", "sat_a kept after clear op", 40'(sat_a), 40'd1);
        do_op(0, 0, 2'b00, 16'd0, 16'd0, 0, 1, "R9");
        chk("R9", "sat_a cleared", 40'(sat_a), 40'd0);
        do_op(1, 0, 2'b11, 16'h7FFF, 16'h7FFF, 1, 0, "R9");
        do_op(1, 0, 2'b01, 16'h7FFF, 16'h7FFF, 1, 0, "R9");
        do_op(1, 0, 2'b01, 16'h7FFF, 16'h7FFF, 1, 1, "R9");
        chk("R9", "event wins over clear", 40'(sat_a), 40'd1);
    endtask

    task automatic t_wide_wrap();
        do_op(0, 0, 2'b00, 16'd0, 16'd0, 0, 1, "R9");
        do_op(1, 1, 2'b00, 16'd0, 16'd0, 0, 0, "R4");
        for (int i = 0; i < 520; i++) do_op(1, 1, 2'b01, 16'h8000, 16'h8000, 0, 0, "R8");
        chk("R8", "wrapped value", acc_b, 40'h8000000000 + 40'd8 * 40'h0040000000);
        chk("R8", "sat_b after 40-bit wrap", 40'(sat_b), 40'd1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_ovf_wrap();
        t_clamp();
        t_sticky();
        t_wide_wrap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule